// File: doc/BRIEF.md
# Slotted Four-Input Output Cell Buffer

This block is the queue behind one output port of a non-blocking switch. Time is divided into slots, and a one-cycle strobe marks each slot. In every slot, up to four input streams may each offer one cell, identified by a small tag. The port may send at most one stored cell. The cells wait in a shared circular store that holds `DEPTH` entries and leave in first-in, first-out order.

Within a slot the departure is taken first. The arrivals then compete for the room that remains, and the lower-numbered streams are served first. A cell that finds no room is dropped. Two running counters record how many cells were offered and how many were lost. The block also reports its occupancy.

Top module: `slot_outbuf`

## Requirements
- R1: Occupancy (`occ_o`) never exceeds `DEPTH`.
- R2: Each strobe removes at most one cell. In the cycle after a strobe, `out_vld_o` is 1 if the buffer held one or more cells before that strobe, and `out_id_o` then carries the oldest stored tag. If the buffer was empty, `out_vld_o` is 0. `out_vld_o` is 0 in every other cycle.
- R3: The departure is removed before arrivals are admitted. When the buffer is full and a cell departs, exactly one arriving cell is accepted and the occupancy stays at `DEPTH`.
- R4: A cell that arrives with a strobe cannot depart with that same strobe. A single arrival into an empty buffer gives `out_vld_o` = 0 for that slot, and the cell leaves on the next strobe.
- R5: An arriving cell that finds no free entry is discarded, and `loss_cnt_o` increases by one for it.
- R6: Arrivals are admitted in stream index order, with `in_vld_i[0]` first. When room runs out, the higher-indexed streams are the ones dropped.
- R7: `arr_cnt_o` increases by the number of set `in_vld_i` bits at each strobe. The occupancy changes by the number of admitted cells minus the departure.
- R8: Cells leave in arrival order. Cells from earlier slots leave first, and within one slot the lower stream index leaves first. The tag of stream k is `in_id_i[k*ID_W +: ID_W]`.
- R9: Input valids and tags have no effect while `slot_i` is 0.
- R10: After reset, occupancy is 0, `out_vld_o` is 0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_i | input | 1 | Slot strobe, one cycle per slot |
| in_vld_i | input | NUM_IN | Per-stream cell present this slot |
| in_id_i | input | NUM_IN*ID_W | Per-stream cell tags, stream k at bits k*ID_W +: ID_W |
| out_vld_o | output | 1 | Departing cell valid, one cycle after the strobe |
| out_id_o | output | ID_W | Departing cell tag |
| occ_o | output | $clog2(DEPTH+1) | Cells currently stored |
| arr_cnt_o | output | CNT_W | Total offered cells |
| loss_cnt_o | output | CNT_W | Total discarded cells |

## Verification
The bench builds the block with `DEPTH` = 6 and keeps four streams, 8-bit tags and 16-bit saturating counters. A shallow store means two full-load slots are enough to fill it. That brings the full-buffer slot within reach of a short directed run: one departure, one admitted cell and three losses. It also reaches pointer wrap-around several times and shows which streams lose under the stream ordering. A bench-side queue model predicts every departing tag, so any reordering across the wrap shows up directly.

// File: rtl/slot_outbuf_pkg.sv
`timescale 1ns/1ps
package slot_outbuf_pkg;
   typedef enum logic {CNT_WRAP = 1'b0, CNT_SATURATE = 1'b1} cnt_mode_e;
endpackage

// File: rtl/slot_outbuf_admit.sv
`timescale 1ns/1ps
// Grants arrivals in stream order against the room left after departure.
module slot_outbuf_admit #(
   parameter int NUM_IN = 4,
   parameter int OCC_W  = 5,
   parameter int PTR_W  = 4,
   parameter int CNT_IN_W = 3
) (
   input  logic [NUM_IN-1:0]         vld_i,
   input  logic [OCC_W-1:0]          room_i,
   output logic [NUM_IN-1:0]         grant_o,
   output logic [NUM_IN-1:0][PTR_W-1:0] ofs_o,
   output logic [CNT_IN_W-1:0]       n_grant_o,
   output logic [CNT_IN_W-1:0]       n_offer_o
);
   logic [OCC_W-1:0] run;
   always_comb begin
      run       = '0;
      n_offer_o = '0;
      grant_o   = '0;
      for (int k = 0; k < NUM_IN; k++) begin
         ofs_o[k]   = run[PTR_W-1:0];
         grant_o[k] = vld_i[k] && (run < room_i);
         if (grant_o[k]) run = run + 1'b1;
         if (vld_i[k]) n_offer_o = n_offer_o + 1'b1;
      end
      n_grant_o = run[CNT_IN_W-1:0];
   end
endmodule

// File: rtl/slot_outbuf_mem.sv
`timescale 1ns/1ps
// Circular cell-tag store with several write ports and one read port.
module slot_outbuf_mem #(
   parameter int DEPTH  = 16,
   parameter int NUM_IN = 4,
   parameter int ID_W   = 8,
   parameter int PTR_W  = 4
) (
   input  logic                          clk,
   input  logic [NUM_IN-1:0]             we_i,
   input  logic [NUM_IN-1:0][PTR_W-1:0]  addr_i,
   input  logic [NUM_IN*ID_W-1:0]        data_i,
   input  logic [PTR_W-1:0]              rd_addr_i,
   output logic [ID_W-1:0]               rd_data_o
);
   logic [DEPTH-1:0][ID_W-1:0] store;

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
         for (int k = 0; k < NUM_IN; k++) begin
            if (we_i[k] && (addr_i[k] == PTR_W'(e)))
               store[e] <= data_i[k*ID_W +: ID_W];
         end
      end
   end

   assign rd_data_o = store[rd_addr_i];
endmodule

// File: rtl/slot_outbuf_ctr.sv
`timescale 1ns/1ps
module slot_outbuf_ctr #(
   parameter int W     = 16,
   parameter int INC_W = 3,
   parameter slot_outbuf_pkg::cnt_mode_e MODE = slot_outbuf_pkg::CNT_SATURATE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [INC_W-1:0] inc_i,
   output logic [W-1:0]     val_o
);
   logic [W:0] sum;
   assign sum = {1'b0, val_o} + (W+1)'(inc_i);

   if (MODE == slot_outbuf_pkg::CNT_SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n)    val_o <= '0;
         else if (en_i) val_o <= sum[W] ? {W{1'b1}} : sum[W-1:0];
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)    val_o <= '0;
         else if (en_i) val_o <= sum[W-1:0];
      end
   end
endmodule

// File: rtl/slot_outbuf.sv
`timescale 1ns/1ps
module slot_outbuf #(
   parameter int DEPTH  = 16,
   parameter int NUM_IN = 4,
   parameter int ID_W   = 8,
   parameter int CNT_W  = 16,
   parameter slot_outbuf_pkg::cnt_mode_e CNT_MODE = slot_outbuf_pkg::CNT_SATURATE
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        slot_i,
   input  logic [NUM_IN-1:0]           in_vld_i,
   input  logic [NUM_IN*ID_W-1:0]      in_id_i,
   output logic                        out_vld_o,
   output logic [ID_W-1:0]             out_id_o,
   output logic [$clog2(DEPTH+1)-1:0]  occ_o,
   output logic [CNT_W-1:0]            arr_cnt_o,
   output logic [CNT_W-1:0]            loss_cnt_o
);
   localparam int OCC_W    = $clog2(DEPTH+1);
   localparam int PTR_W    = $clog2(DEPTH);
   localparam int CNT_IN_W = $clog2(NUM_IN+1);

   initial begin
      if (DEPTH < 2)       $error("DEPTH must be at least 2");
      if (NUM_IN < 1)      $error("NUM_IN must be at least 1");
      if (NUM_IN > DEPTH)  $error("NUM_IN must not exceed DEPTH");
      if (CNT_W < CNT_IN_W) $error("CNT_W too narrow");
   end

   logic [PTR_W-1:0] rd_ptr, wr_ptr;
   logic             dep;
   logic [OCC_W-1:0] room;
   logic [NUM_IN-1:0] grant;
   logic [NUM_IN-1:0][PTR_W-1:0] ofs, waddr;
   logic [CNT_IN_W-1:0] n_grant, n_offer;
   logic [ID_W-1:0]  rd_data;

   assign dep  = slot_i && (occ_o != '0);
   assign room = OCC_W'(DEPTH) - occ_o + OCC_W'(dep);

   slot_outbuf_admit #(.NUM_IN(NUM_IN), .OCC_W(OCC_W), .PTR_W(PTR_W), .CNT_IN_W(CNT_IN_W)) u_admit (
      .vld_i    (in_vld_i & {NUM_IN{slot_i}}),
      .room_i   (room),
      .grant_o  (grant),
      .ofs_o    (ofs),
      .n_grant_o(n_grant),
      .n_offer_o(n_offer)
   );

   function automatic logic [PTR_W-1:0] wrap_add(logic [PTR_W-1:0] base, logic [PTR_W:0] inc);
      logic [PTR_W:0] s;
      s = {1'b0, base} + inc;
      if (s >= (PTR_W+1)'(DEPTH)) s = s - (PTR_W+1)'(DEPTH);
      return s[PTR_W-1:0];
   endfunction

   for (genvar k = 0; k < NUM_IN; k++) begin : g_waddr
      assign waddr[k] = wrap_add(wr_ptr, {1'b0, ofs[k]});
   end

   slot_outbuf_mem #(.DEPTH(DEPTH), .NUM_IN(NUM_IN), .ID_W(ID_W), .PTR_W(PTR_W)) u_mem (
      .clk      (clk),
      .we_i     (grant),
      .addr_i   (waddr),
      .data_i   (in_id_i),
      .rd_addr_i(rd_ptr),
      .rd_data_o(rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr    <= '0;
         wr_ptr    <= '0;
         occ_o     <= '0;
         out_vld_o <= 1'b0;
         out_id_o  <= '0;
      end else begin
         out_vld_o <= dep;
         if (slot_i) begin
            if (dep) begin
               out_id_o <= rd_data;
               rd_ptr   <= wrap_add(rd_ptr, (PTR_W+1)'(1));
            end
            wr_ptr <= wrap_add(wr_ptr, (PTR_W+1)'(n_grant));
            occ_o  <= occ_o - OCC_W'(dep) + OCC_W'(n_grant);
         end
      end
   end

   slot_outbuf_ctr #(.W(CNT_W), .INC_W(CNT_IN_W), .MODE(CNT_MODE)) u_arr (
      .clk(clk), .rst_n(rst_n), .en_i(slot_i), .inc_i(n_offer), .val_o(arr_cnt_o)
   );
   slot_outbuf_ctr #(.W(CNT_W), .INC_W(CNT_IN_W), .MODE(CNT_MODE)) u_loss (
      .clk(clk), .rst_n(rst_n), .en_i(slot_i), .inc_i(n_offer - n_grant), .val_o(loss_cnt_o)
   );
endmodule

// File: rtl/slot_outbuf_chk.sv
`timescale 1ns/1ps
module slot_outbuf_chk #(
   parameter int DEPTH  = 16,
   parameter int NUM_IN = 4,
   parameter int ID_W   = 8,
   parameter int CNT_W  = 16,
   parameter slot_outbuf_pkg::cnt_mode_e CNT_MODE = slot_outbuf_pkg::CNT_SATURATE
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       slot_i,
   input logic [NUM_IN-1:0]          in_vld_i,
   input logic                       out_vld_o,
   input logic [$clog2(DEPTH+1)-1:0] occ_o,
   input logic [CNT_W-1:0]           arr_cnt_o,
   input logic [CNT_W-1:0]           loss_cnt_o
);
   AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      occ_o <= ($clog2(DEPTH+1))'(DEPTH)); // R1
   AST_OUT_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld_o |-> $past(slot_i)); // R2
   AST_NO_DEP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_i && occ_o == '0) |=> !out_vld_o); // R4
   AST_DEP_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_i && occ_o != '0) |=> out_vld_o); // R2
   AST_LOSS_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      slot_i |=> (loss_cnt_o == $past(loss_cnt_o)) || (occ_o == ($clog2(DEPTH+1))'(DEPTH))); // R5
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_i |=> $stable(occ_o) && $stable(arr_cnt_o) && $stable(loss_cnt_o)); // R9
   if (CNT_MODE == slot_outbuf_pkg::CNT_SATURATE) begin : g_sat_chk
      AST_LOSS_LE_ARR: assert property (@(posedge clk) disable iff (!rst_n)
         loss_cnt_o <= arr_cnt_o); // R7
   end
endmodule

bind slot_outbuf slot_outbuf_chk #(
   .DEPTH(DEPTH), .NUM_IN(NUM_IN), .ID_W(ID_W), .CNT_W(CNT_W), .CNT_MODE(CNT_MODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .slot_i(slot_i), .in_vld_i(in_vld_i),
   .out_vld_o(out_vld_o), .occ_o(occ_o), .arr_cnt_o(arr_cnt_o), .loss_cnt_o(loss_cnt_o)
);

// File: tb/slot_outbuf_bench.sv
`timescale 1ns/1ps
module slot_outbuf_bench;
   localparam int D  = 6;
   localparam int NI = 4;
   localparam int IW = 8;
   localparam int CW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slot_i = 1'b0;
   logic [NI-1:0] in_vld_i = '0;
   logic [NI*IW-1:0] in_id_i = '0;
   logic out_vld_o;
   logic [IW-1:0] out_id_o;
   logic [$clog2(D+1)-1:0] occ_o;
   logic [CW-1:0] arr_cnt_o, loss_cnt_o;

   always #2 clk = ~clk;

   slot_outbuf #(.DEPTH(D), .NUM_IN(NI), .ID_W(IW), .CNT_W(CW)) u_slot_outbuf (
      .clk(clk), .rst_n(rst_n), .slot_i(slot_i), .in_vld_i(in_vld_i), .in_id_i(in_id_i),
      .out_vld_o(out_vld_o), .out_id_o(out_id_o), .occ_o(occ_o),
      .arr_cnt_o(arr_cnt_o), .loss_cnt_o(loss_cnt_o)
   );

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;
   logic [IW-1:0] model_q[$];
   int exp_arr = 0, exp_loss = 0;
   logic [IW-1:0] next_id = 8'h10;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One slot: drive streams, update the model, check outputs after the edge.
   task automatic do_slot(input logic [NI-1:0] v, input string tag);
      bit e_vld;
      logic [IW-1:0] e_id;
      e_id = '0;
      @(negedge clk);
      slot_i = 1'b1;
      in_vld_i = v;
      for (int k = 0; k < NI; k++) begin
         in_id_i[k*IW +: IW] = next_id;
         next_id = next_id + 1'b1;
      end
      e_vld = (model_q.size() != 0);
      if (e_vld) e_id = model_q.pop_front();
      for (int k = 0; k < NI; k++) begin
         if (v[k]) begin
            exp_arr++;
            if (model_q.size() < D) model_q.push_back(in_id_i[k*IW +: IW]);
            else exp_loss++;
         end
      end
      @(posedge clk);
      #1;
      chk(out_vld_o == e_vld, {tag, " R2 out_vld"}, int'(out_vld_o), int'(e_vld));
      if (e_vld) chk(out_id_o == e_id, {tag, " R8 out_id"}, int'(out_id_o), int'(e_id));
      chk(occ_o == model_q.size(), {tag, " R7 occ"}, int'(occ_o), model_q.size());
      chk(occ_o <= D, {tag, " R1 bound"}, int'(occ_o), D);
      chk(arr_cnt_o == exp_arr, {tag, " R7 arrivals"}, int'(arr_cnt_o), exp_arr);
      chk(loss_cnt_o == exp_loss, {tag, " R5 losses"}, int'(loss_cnt_o), exp_loss);
      @(negedge clk);
      slot_i = 1'b0;
      in_vld_i = '0;
   endtask

   task automatic t_reset();
      #1;
      chk(occ_o == 0, "R10 occ", int'(occ_o), 0);
      chk(out_vld_o == 0, "R10 out_vld", int'(out_vld_o), 0);
      chk(arr_cnt_o == 0, "R10 arrivals", int'(arr_cnt_o), 0);
      chk(loss_cnt_o == 0, "R10 losses", int'(loss_cnt_o), 0);
   endtask

   task automatic t_same_slot();
      do_slot(4'b0001, "R4 arrive-empty");
      chk(out_vld_o == 0, "R4 no same-slot departure", int'(out_vld_o), 0);
      do_slot(4'b0000, "R4 next-slot departure");
   endtask

   task automatic t_fifo_mix();
      do_slot(4'b1010, "R8 mix-a");
      do_slot(4'b0111, "R8 mix-b");
      do_slot(4'b0001, "R8 mix-c");
      do_slot(4'b1000, "R8 mix-d");
      do_slot(4'b0000, "R8 mix-e");
   endtask

   task automatic t_overflow();
      int loss_before;
      do_slot(4'b1111, "R6 fill-a");
      do_slot(4'b1111, "R6 fill-b");
      do_slot(4'b1111, "R6 fill-c");
      chk(occ_o == D, "R3 full before", int'(occ_o), D);
      loss_before = int'(loss_cnt_o);
      do_slot(4'b1111, "R3 full-slot");
      chk(occ_o == D, "R3 full after", int'(occ_o), D);
      chk(int'(loss_cnt_o) - loss_before == 3, "R5 three lost", int'(loss_cnt_o) - loss_before, 3);
      do_slot(4'b1100, "R6 upper-streams");
   endtask

   task automatic t_idle();
      int occ0, arr0, loss0;
      occ0 = int'(occ_o); arr0 = int'(arr_cnt_o); loss0 = int'(loss_cnt_o);
      @(negedge clk);
      in_vld_i = 4'hF;
      in_id_i = '1;
      repeat (3) @(negedge clk);
      chk(int'(occ_o) == occ0, "R9 idle occ", int'(occ_o), occ0);
      chk(int'(arr_cnt_o) == arr0, "R9 idle arrivals", int'(arr_cnt_o), arr0);
      chk(int'(loss_cnt_o) == loss0, "R9 idle losses", int'(loss_cnt_o), loss0);
      chk(out_vld_o == 0, "R9 idle out_vld", int'(out_vld_o), 0);
      in_vld_i = '0;
   endtask

   task automatic t_drain();
      for (int i = 0; i < D + 2; i++) do_slot(4'b0000, "R8 drain");
      chk(occ_o == 0, "R2 drained", int'(occ_o), 0);
      chk(out_vld_o == 0, "R2 empty no output", int'(out_vld_o), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_same_slot();
      t_fifo_mix();
      t_overflow();
      t_idle();
      t_drain();
      t_fifo_mix();
      t_drain();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule